// File: doc/BRIEF.md
# Block Float-to-Fixed Gradient Quantizer

This block sits between a worker's gradient store and an integer-only aggregation fabric. In the forward path it takes single-precision gradients one per cycle and turns each one into a signed 32-bit fixed-point word. The scale comes from a shared exponent that all workers agreed on beforehand and from the worker count n = 2^LG_WORKERS. The scale is chosen so that adding n such words can never leave the signed 32-bit range. In the reverse path it takes the aggregated integer sums one per cycle and turns them back into single precision. As an option it also divides by n to give a mean.

A third input stream scans the raw gradients of the next local block. After every BLOCK_K scanned elements the block reports that block's maximum exponent, rounded up. The host sends this value along with the current block, so the workers can agree on the exponent for the next round. Words flagged as non-gradient data cross both paths untouched.

Top module: `grad_fxp_quantizer`

## Requirements
- R1: Floats use sign bit 31, biased exponent bits 30:23 and mantissa bits 22:0. With shared biased exponent e on `fwd_exp` and L = LG_WORKERS, a gradient with biased exponent 1..254 becomes sign × trunc(|v| × 2^(158 − L − e)) as a two's-complement word on `fq_data`.
- R2: The magnitude of every forward gradient result is clipped to 2^(31−L) − 1. Infinities and NaNs give that clip value with the input's sign, so n results always sum without overflow.
- R3: Forward gradients with exponent field 0 (zeros of either sign and denormals) give 0.
- R4: Negative forward results are truncated toward zero, to the negation of the truncated magnitude.
- R5: When `fwd_grad` or `rev_grad` is low, the input word appears unchanged on the matching output.
- R6: Each path has one cycle of latency. `fq_valid`/`rf_valid` is high exactly in the cycle after `fwd_valid`/`rev_valid` was high.
- R7: After every BLOCK_K-th accepted `scan_valid` element, `ahead_valid` pulses for one cycle. In that cycle `ahead_exp` holds the block's largest biased exponent. That value is increased by one if any mantissa field in the block is nonzero, and the result is capped at 255.
- R8: A reverse gradient integer x becomes x × 2^(e − 158 + L) in single precision, using e from `rev_exp`. Its 24-bit significand is truncated, not rounded.
- R9: With `rev_avg` high, the reverse result is further divided by n. The exponent is lowered by L.
- R10: A reverse integer of 0, or a result whose biased exponent would be ≤ 0, gives 0x00000000. A result whose biased exponent would be ≥ 255 gives infinity with the integer's sign.
- R11: Reset clears both output valids, `ahead_valid`, the output data and the scan element count. A partly scanned block is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_valid | input | 1 | Forward element present |
| fwd_grad | input | 1 | Forward element is a gradient (else pass through) |
| fwd_data | input | 32 | Forward single-precision input |
| fwd_exp | input | 8 | Agreed biased shared exponent for forward scaling |
| fq_valid | output | 1 | Forward result valid |
| fq_data | output | 32 | Fixed-point result or passed word |
| scan_valid | input | 1 | Look-ahead element present |
| scan_data | input | 32 | Look-ahead single-precision element |
| ahead_valid | output | 1 | Rounded-up block exponent ready |
| ahead_exp | output | 8 | Rounded-up block maximum biased exponent |
| rev_valid | input | 1 | Reverse element present |
| rev_grad | input | 1 | Reverse element is an aggregated gradient |
| rev_avg | input | 1 | Also divide the result by the worker count |
| rev_data | input | 32 | Aggregated two's-complement integer |
| rev_exp | input | 8 | Biased shared exponent used for this block |
| rf_valid | output | 1 | Reverse result valid |
| rf_data | output | 32 | Single-precision result or passed word |

## Verification
The bench goes after the edges of the forward scale. It uses values that land exactly on the power of two equal to the shared exponent, infinities, NaNs, denormals and negative values that need right shifts. A design with an off-by-one shift or no clip would put out 2^(31−L) and let an n-way sum wrap. A design that rounds the wrong way would be off by one LSB on negatives. On the reverse path, −2^31, 0x7FFFFFFF, the averaging option and exponent underflow or overflow are hit. A wrong leading-one search or rounding instead of truncation shows up as a changed mantissa. A missing saturation shows up as a wrapped exponent. The scan stream is checked for the pulse timing and for the mantissa-driven round-up, including the cap at 255. It is also checked across a reset in the middle of a block, where a counter that keeps its count would fire early.

// File: rtl/gq_pkg.sv
package gq_pkg;

  // Float to scaled integer. lg is log2 of the worker count.
  function automatic logic [31:0] gq_to_fixed(input logic [31:0] f,
                                              input logic [7:0]  e_sh,
                                              input int          lg);
    logic [7:0]  ex;
    logic [23:0] man;
    logic [63:0] mag;
    logic [63:0] lim;
    logic [31:0] r;
    int          sh;
    ex  = f[30:23];
    man = {1'b1, f[22:0]};
    lim = (64'd1 << (31 - lg)) - 64'd1;
    sh  = int'(ex) - int'(e_sh) + 8 - lg;
    if (ex == 8'd0)            mag = 64'd0;
    else if (ex == 8'hFF)      mag = lim;
    else if (sh > 8)           mag = lim;
    else if (sh >= 0)          mag = {40'd0, man} << sh;
    else if (sh <= -24)        mag = 64'd0;
    else                       mag = {40'd0, man} >> (-sh);
    if (mag > lim) mag = lim;
    r = mag[31:0];
    if (f[31]) r = -r;
    return r;
  endfunction

  // Scaled integer back to float; avg drops the worker-count factor.
  function automatic logic [31:0] gq_to_float(input logic [31:0] x,
                                              input logic [7:0]  e_sh,
                                              input int          lg,
                                              input logic        avg);
    logic        sgn;
    logic [31:0] mag;
    logic [31:0] nrm;
    int          p;
    int          eo;
    sgn = x[31];
    mag = sgn ? (~x + 32'd1) : x;
    p   = -1;
    for (int i = 0; i < 32; i++) begin
      if (mag[i]) p = i;
    end
    if (p < 0) return 32'd0;
    nrm = mag << (31 - p);
    eo  = p + int'(e_sh) - 31 + (avg ? 0 : lg);
    if (eo <= 0)   return 32'd0;
    if (eo >= 255) return {sgn, 8'hFF, 23'd0};
    return {sgn, eo[7:0], nrm[30:8]};
  endfunction

  // Round a block maximum exponent upward when fractions exist.
  function automatic logic [7:0] gq_round_exp(input logic [7:0] emax,
                                              input logic       any_frac);
    if (any_frac && emax != 8'hFF) return emax + 8'd1;
    return emax;
  endfunction

endpackage

// File: rtl/gq_fwd_path.sv
module gq_fwd_path
  import gq_pkg::*;
#(
  parameter int LG_WORKERS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_grad,
  input  logic [31:0] in_data,
  input  logic [7:0]  sh_exp,
  output logic        out_valid,
  output logic [31:0] out_data
);
  localparam logic [31:0] LIM = (32'd1 << (31 - LG_WORKERS)) - 32'd1;

  logic [31:0] conv_w;
  logic        out_grad_q;

  assign conv_w = gq_to_fixed(in_data, sh_exp, LG_WORKERS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_grad_q <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_grad_q <= in_grad;
        out_data   <= in_grad ? conv_w : in_data;
      end
    end
  end

  // R2
  fwd_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_grad_q |->
      ($signed(out_data) <= $signed(LIM)) && ($signed(out_data) >= -$signed(LIM)));
  // R3
  fwd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_grad && (in_data[30:23] == 8'd0) |=> out_data == 32'd0);
  // R5
  fwd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_grad_q |-> out_data == $past(in_data));
  // R6
  fwd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
endmodule

// File: rtl/gq_rev_path.sv
module gq_rev_path
  import gq_pkg::*;
#(
  parameter int LG_WORKERS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_grad,
  input  logic        in_avg,
  input  logic [31:0] in_data,
  input  logic [7:0]  sh_exp,
  output logic        out_valid,
  output logic [31:0] out_data
);
  logic [31:0] conv_w;
  logic        out_grad_q;

  assign conv_w = gq_to_float(in_data, sh_exp, LG_WORKERS, in_avg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_grad_q <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_grad_q <= in_grad;
        out_data   <= in_grad ? conv_w : in_data;
      end
    end
  end

  // R8
  rev_no_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_grad_q |-> !((out_data[30:23] == 8'hFF) && (out_data[22:0] != 23'd0)));
  // R10
  rev_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_grad && (in_data == 32'd0) |=> out_data == 32'd0);
  // R5
  rev_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_grad_q |-> out_data == $past(in_data));
  // R6
  rev_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/gq_exp_scan.sv
module gq_exp_scan
  import gq_pkg::*;
#(
  parameter int BLOCK_K = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_valid,
  input  logic [31:0] scan_data,
  output logic        ahead_valid,
  output logic [7:0]  ahead_exp
);
  localparam int CW = (BLOCK_K > 1) ? $clog2(BLOCK_K) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLOCK_K - 1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    max_q;
  logic          frac_q;
  logic [7:0]    ex_w;
  logic [7:0]    max_w;
  logic          frac_w;
  logic          first_w;
  logic          blk_done_w;

  always_comb begin
    ex_w       = scan_data[30:23];
    first_w    = (cnt_q == '0);
    max_w      = (first_w || (ex_w > max_q)) ? ex_w : max_q;
    frac_w     = (scan_data[22:0] != 23'd0) || (!first_w && frac_q);
    blk_done_w = scan_valid && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      max_q       <= '0;
      frac_q      <= 1'b0;
      ahead_valid <= 1'b0;
      ahead_exp   <= '0;
    end else begin
      ahead_valid <= blk_done_w;
      if (scan_valid) begin
        cnt_q  <= blk_done_w ? '0 : cnt_q + 1'b1;
        max_q  <= max_w;
        frac_q <= frac_w;
      end
      if (blk_done_w) ahead_exp <= gq_round_exp(max_w, frac_w);
    end
  end

  // R7
  scan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_w |=> ahead_valid);
  // R7
  scan_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ahead_valid |-> $past(scan_valid));
  // R11
  scan_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/grad_fxp_quantizer.sv
module grad_fxp_quantizer #(
  parameter int LG_WORKERS = 3,
  parameter int BLOCK_K    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fwd_valid,
  input  logic        fwd_grad,
  input  logic [31:0] fwd_data,
  input  logic [7:0]  fwd_exp,
  output logic        fq_valid,
  output logic [31:0] fq_data,
  input  logic        scan_valid,
  input  logic [31:0] scan_data,
  output logic        ahead_valid,
  output logic [7:0]  ahead_exp,
  input  logic        rev_valid,
  input  logic        rev_grad,
  input  logic        rev_avg,
  input  logic [31:0] rev_data,
  input  logic [7:0]  rev_exp,
  output logic        rf_valid,
  output logic [31:0] rf_data
);
  gq_fwd_path #(.LG_WORKERS(LG_WORKERS)) fwd_u (
    .clk(clk), .rst_n(rst_n), .in_valid(fwd_valid), .in_grad(fwd_grad),
    .in_data(fwd_data), .sh_exp(fwd_exp), .out_valid(fq_valid), .out_data(fq_data));

  gq_exp_scan #(.BLOCK_K(BLOCK_K)) scan_u (
    .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .scan_data(scan_data),
    .ahead_valid(ahead_valid), .ahead_exp(ahead_exp));

  gq_rev_path #(.LG_WORKERS(LG_WORKERS)) rev_u (
    .clk(clk), .rst_n(rst_n), .in_valid(rev_valid), .in_grad(rev_grad),
    .in_avg(rev_avg), .in_data(rev_data), .sh_exp(rev_exp),
    .out_valid(rf_valid), .out_data(rf_data));
endmodule

// File: tb/grad_fxp_quantizer_tb_top.sv
`timescale 1ns/1ps
module grad_fxp_quantizer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_valid = 0, fwd_grad = 0;
  logic [31:0] fwd_data = 0;
  logic [7:0] fwd_exp = 0;
  logic fq_valid;
  logic [31:0] fq_data;
  logic scan_valid = 0;
  logic [31:0] scan_data = 0;
  logic ahead_valid;
  logic [7:0] ahead_exp;
  logic rev_valid = 0, rev_grad = 0, rev_avg = 0;
  logic [31:0] rev_data = 0;
  logic [7:0] rev_exp = 0;
  logic rf_valid;
  logic [31:0] rf_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grad_fxp_quantizer #(.LG_WORKERS(3), .BLOCK_K(4)) dut_i (.*);

  // {req, shared exp, input float, expected fixed}, n = 8
  localparam logic [75:0] FWD_TAB [0:14] = '{
    {4'd1, 8'h80, 32'h3F800000, 32'h08000000},  // R1
    {4'd1, 8'h80, 32'hBFC00000, 32'hF4000000},  // R1
    {4'd1, 8'h80, 32'h3F000000, 32'h04000000},  // R1
    {4'd1, 8'h80, 32'h3F800001, 32'h08000010},  // R1
    {4'd1, 8'h7F, 32'h3F7FFFFF, 32'h0FFFFFF0},  // R1
    {4'd2, 8'h80, 32'h40000000, 32'h0FFFFFFF},  // R2
    {4'd2, 8'h80, 32'h7F800000, 32'h0FFFFFFF},  // R2
    {4'd2, 8'h80, 32'hFF800000, 32'hF0000001},  // R2
    {4'd2, 8'h80, 32'hFFC00000, 32'hF0000001},  // R2
    {4'd3, 8'h80, 32'h00000001, 32'h00000000},  // R3
    {4'd3, 8'h80, 32'h807FFFFF, 32'h00000000},  // R3
    {4'd3, 8'h80, 32'h80000000, 32'h00000000},  // R3
    {4'd4, 8'hA0, 32'h4B000007, 32'h00040000},  // R4
    {4'd4, 8'hA0, 32'hCB000007, 32'hFFFC0000},  // R4
    {4'd4, 8'h80, 32'h30800000, 32'h00000000}   // R4
  };
  // {req, avg, shared exp, input int, expected float}
  localparam logic [76:0] REV_TAB [0:9] = '{
    {4'd8,  1'b0, 8'h80, 32'h08000000, 32'h3F800000},  // R8
    {4'd8,  1'b0, 8'h80, 32'hF4000000, 32'hBFC00000},  // R8
    {4'd8,  1'b0, 8'h80, 32'h80000000, 32'hC1800000},  // R8
    {4'd8,  1'b0, 8'h80, 32'h7FFFFFFF, 32'h417FFFFF},  // R8
    {4'd9,  1'b1, 8'h80, 32'h40000000, 32'h3F800000},  // R9
    {4'd9,  1'b1, 8'h80, 32'hC0000000, 32'hBF800000},  // R9
    {4'd10, 1'b0, 8'h80, 32'h00000000, 32'h00000000},  // R10
    {4'd10, 1'b0, 8'h01, 32'h00000001, 32'h00000000},  // R10
    {4'd10, 1'b0, 8'hFE, 32'h7FFFFFFF, 32'h7F800000},  // R10
    {4'd10, 1'b0, 8'hFE, 32'h80000001, 32'hFF800000}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fwd_one(input logic [31:0] d, input logic [7:0] e, input logic g);
    @(negedge clk);
    fwd_valid = 1; fwd_grad = g; fwd_data = d; fwd_exp = e;
    @(posedge clk); #1;
    @(negedge clk);
    fwd_valid = 0;
  endtask

  task automatic rev_one(input logic [31:0] d, input logic [7:0] e, input logic g, input logic a);
    @(negedge clk);
    rev_valid = 1; rev_grad = g; rev_data = d; rev_exp = e; rev_avg = a;
    @(posedge clk); #1;
    @(negedge clk);
    rev_valid = 0;
  endtask

  task automatic scan_blk(input logic [31:0] a, b, c, d, input logic [7:0] exp, input string req);
    logic [31:0] v [4];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      scan_valid = 1; scan_data = v[i];
      @(posedge clk); #1;
      chk(req, {31'd0, ahead_valid}, {31'd0, (i == 3)});
      if (i == 3) chk(req, {24'd0, ahead_exp}, {24'd0, exp});
    end
    @(negedge clk);
    scan_valid = 0;
    @(posedge clk); #1;
    chk(req, {31'd0, ahead_valid}, 32'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11", {29'd0, fq_valid, rf_valid, ahead_valid}, 32'd0);
    chk("R11", fq_data | rf_data, 32'd0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 15; i++) begin
      fwd_one(FWD_TAB[i][63:32], FWD_TAB[i][71:64], 1'b1);
      chk($sformatf("R%0d", FWD_TAB[i][75:72]), fq_data, FWD_TAB[i][31:0]);
    end
    for (int i = 0; i < 10; i++) begin
      rev_one(REV_TAB[i][63:32], REV_TAB[i][71:64], 1'b1, REV_TAB[i][72]);
      chk($sformatf("R%0d", REV_TAB[i][76:73]), rf_data, REV_TAB[i][31:0]);
    end

    // R5 pass-through on both paths
    fwd_one(32'hDEADBEEF, 8'h80, 1'b0);
    chk("R5", fq_data, 32'hDEADBEEF);
    rev_one(32'h7FC00001, 8'h80, 1'b0, 1'b0);
    chk("R5", rf_data, 32'h7FC00001);

    // R6 latency: valid one cycle after input, then low
    @(negedge clk);
    fwd_valid = 1; fwd_grad = 1; fwd_data = 32'h3F800000; fwd_exp = 8'h80;
    rev_valid = 1; rev_grad = 1; rev_data = 32'h08000000; rev_exp = 8'h80; rev_avg = 0;
    #1;
    chk("R6", {30'd0, fq_valid, rf_valid}, 32'd0);
    @(posedge clk); #1;
    chk("R6", {30'd0, fq_valid, rf_valid}, 32'd3);
    @(negedge clk); fwd_valid = 0; rev_valid = 0;
    @(posedge clk); #1;
    chk("R6", {30'd0, fq_valid, rf_valid}, 32'd0);

    // R1 and R8 round trip: left shifts below the clip are lossless
    for (int i = 0; i < 12; i++) begin
      logic [31:0] v;
      v = {i[0], 8'd127 - 8'(i % 3), 23'(i * 12345)};
      fwd_one(v, 8'h80, 1'b1);
      keep = fq_data;
      rev_one(keep, 8'h80, 1'b1, 1'b0);
      chk("R1_R8 round trip", rf_data, v);
    end

    // R7 look-ahead exponent
    scan_blk(32'h3F800000, 32'h3F000000, 32'hBFC00000, 32'h00000000, 8'h80, "R7");
    scan_blk(32'h3F800000, 32'h3E800000, 32'h3F000000, 32'hBF800000, 8'h7F, "R7");
    scan_blk(32'h7F000000, 32'h3F800001, 32'h00000000, 32'h00000000, 8'hFF, "R7");
    scan_blk(32'h7FC00000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 8'hFF, "R7");

    // R11 reset mid-block drops the partial count
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); scan_valid = 1; scan_data = 32'h40000000;
    end
    @(negedge clk); scan_valid = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    scan_blk(32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 8'h7F, "R11");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule